// File: doc/BRIEF.md
# Cascadable Vectored Interrupt Controller

This block gathers eight interrupt request lines, masks them, resolves them by a fixed priority against the levels it already has in service, and raises a single interrupt request toward an 8-bit host. The host answers with an acknowledge made of three pulses on `ack_i`. The controller replies with one byte per pulse: a CALL opcode (0xCD), then the low byte and then the high byte of the service routine address. That address is the programmed 16-bit base plus four times the winning level number.

Several copies can be chained. A copy with `master_mode` high is the master and drives the 3-bit cascade lines. A copy with `master_mode` low is a slave, listens on the cascade lines, and sends its `int_o` into one request input of the master. All copies receive the same acknowledge pulses. On a request that comes through a slave, the master sends the opcode and places the winning input number on the cascade lines. The slave whose programmed ID matches that number then supplies both address bytes. Configuration uses a small write port. Address 0 holds the mask, where bit i = 1 masks input i. Address 1 holds the cascade setting: on a master, bit i = 1 marks input i as wired to a slave; on a slave, bits [2:0] are its ID. Address 2 holds the base low byte and address 3 the base high byte. A write to address 4, with any data, is a non-specific end-of-interrupt.

The acknowledge state machine `casc_ack_fsm` has six states: ACK_IDLE, ACK_P1, ACK_G1, ACK_P2, ACK_G2 and ACK_P3. Its transitions are:
- IDLE→P1 when `ack_i` rises. The winner is latched here, and a master sets its in-service bit.
- P1→G1 when `ack_i` falls. A slave compares the cascade lines with its ID here, and on a match it sets its in-service bit.
- G1→P2 and G2→P3 when `ack_i` rises again.
- P2→G2 when `ack_i` falls.
- P3→IDLE when `ack_i` falls. This ends the count.

Each output changes one clock after the `ack_i` edge that caused it. `int_o` is registered, so it follows the inputs by one clock.

Top module: `casc_irq_ctrl`

## Requirements
- R1: After reset, `int_o`, `data_oe` and `cas_oe` are all 0.
- R2: A request on an input whose mask bit (address 0, bit i = 1 masks) is set never raises `int_o`. An unmasked request with nothing in service raises `int_o`.
- R3: Priority is fixed, with input 0 the highest. When several unmasked inputs request, the lowest-numbered one is acknowledged.
- R4: `int_o` is raised only when the best unmasked request has a lower number than every in-service level. A request at or below an in-service level is held off, and a higher one preempts.
- R5: A write to address 4 clears only the in-service bit with the lowest number.
- R6: During the first acknowledge pulse, a master drives 0xCD with `data_oe` high, and a slave never drives the data bus.
- R7: For a winner on a direct master input, the master drives the low byte of base+4×level on pulse 2 and the high byte on pulse 3.
- R8: For a winner on an input marked as slave-wired (address 1, bit i = 1), the master drives `cas_o` equal to that input number with `cas_oe` high, and drives no data on pulses 2 and 3.
- R9: Only a slave whose ID (address 1, bits [2:0]) equals the cascade value during pulse 1 drives pulses 2 and 3, with the low byte and then the high byte of its own base+4×level. A slave with another ID stays off the bus.
- R10: `data_oe` is high only in pulses whose byte the device owns, so two devices never drive the bus together. After the third pulse the count returns to idle, and the next pulse starts a new acknowledge.
- R11: With `master_mode` low, `cas_oe` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| master_mode | input | 1 | 1 = master, 0 = slave |
| irq_i | input | 8 | Interrupt request levels |
| int_o | output | 1 | Interrupt request to host or master |
| ack_i | input | 1 | Acknowledge pulse from host, active high |
| cas_i | input | 3 | Cascade lines in (slave) |
| cas_o | output | 3 | Cascade lines out (master) |
| cas_oe | output | 1 | Cascade output enable |
| data_o | output | 8 | Byte driven toward the host |
| data_oe | output | 1 | Data bus drive enable |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 8 | Register write data |

## Verification
The hardest case to reach is a slave acknowledge that has to win against levels already in service in both devices, followed by end-of-interrupt writes that must peel the in-service levels off one at a time. The bench chains one master with two slaves. It first puts a direct master level into service. It then raises a higher level through a slave, while a second slave with a different ID keeps its own request pending. Interleaved end-of-interrupt writes then show which levels stay in service, by whether `int_o` comes back.

// File: rtl/casc_irq_pkg.sv
package casc_irq_pkg;

    localparam logic [7:0] CALL_OPCODE = 8'hCD;

    typedef enum logic [2:0] {
        ACK_IDLE,
        ACK_P1,
        ACK_G1,
        ACK_P2,
        ACK_G2,
        ACK_P3
    } ack_state_t;

    typedef enum logic [2:0] {
        REG_MASK  = 3'd0,
        REG_CASC  = 3'd1,
        REG_BASEL = 3'd2,
        REG_BASEH = 3'd3,
        REG_EOI   = 3'd4
    } reg_addr_t;

endpackage

// File: rtl/casc_cfg_regs.sv
module casc_cfg_regs
    import casc_irq_pkg::*;
#(
    parameter int N_IRQ  = 8,
    parameter int DATA_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [2:0]          wr_addr,
    input  logic [DATA_W-1:0]   wr_data,
    output logic [N_IRQ-1:0]    mask_q,
    output logic [N_IRQ-1:0]    casc_q,
    output logic [2*DATA_W-1:0] base_q,
    output logic                eoi_stb
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= '0;
            casc_q <= '0;
            base_q <= '0;
        end else if (wr_en) begin
            case (wr_addr)
                REG_MASK:  mask_q <= wr_data[N_IRQ-1:0];
                REG_CASC:  casc_q <= wr_data[N_IRQ-1:0];
                REG_BASEL: base_q[DATA_W-1:0] <= wr_data;
                REG_BASEH: base_q[2*DATA_W-1:DATA_W] <= wr_data;
                default: ;
            endcase
        end
    end

    assign eoi_stb = wr_en && (wr_addr == REG_EOI);

endmodule

// File: rtl/casc_prio_resolve.sv
module casc_prio_resolve #(
    parameter int N_IRQ = 8,
    localparam int IW   = $clog2(N_IRQ)
) (
    input  logic [N_IRQ-1:0] req,
    input  logic [N_IRQ-1:0] mask,
    input  logic [N_IRQ-1:0] isr,
    output logic             raise,
    output logic [IW-1:0]    win_idx,
    output logic             isr_any,
    output logic [IW-1:0]    isr_top
);

    logic [N_IRQ-1:0] pend;
    logic             pend_any;

    assign pend = req & ~mask;

    always_comb begin
        win_idx  = IW'(N_IRQ - 1);
        pend_any = 1'b0;
        isr_top  = IW'(N_IRQ - 1);
        isr_any  = 1'b0;
        for (int i = N_IRQ - 1; i >= 0; i--) begin
            if (pend[i]) begin
                win_idx  = IW'(i);
                pend_any = 1'b1;
            end
            if (isr[i]) begin
                isr_top = IW'(i);
                isr_any = 1'b1;
            end
        end
        raise = pend_any && (!isr_any || (win_idx < isr_top));
    end

endmodule

// File: rtl/casc_ack_fsm.sv
module casc_ack_fsm
    import casc_irq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ack_i,
    output ack_state_t state,
    output logic       enter_p1,
    output logic       leave_p1
);

    ack_state_t nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ACK_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ACK_IDLE: if (ack_i)  nxt = ACK_P1;
            ACK_P1:   if (!ack_i) nxt = ACK_G1;
            ACK_G1:   if (ack_i)  nxt = ACK_P2;
            ACK_P2:   if (!ack_i) nxt = ACK_G2;
            ACK_G2:   if (ack_i)  nxt = ACK_P3;
            ACK_P3:   if (!ack_i) nxt = ACK_IDLE;
            default:              nxt = ACK_IDLE;
        endcase
    end

    assign enter_p1 = (state == ACK_IDLE) && ack_i;
    assign leave_p1 = (state == ACK_P1) && !ack_i;

    // R10
    p3_returns_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ACK_P3 && !ack_i) |=> (state == ACK_IDLE));

    // R10
    p1_follows_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state == ACK_P1) |-> $past(state == ACK_IDLE));

endmodule

// File: rtl/casc_irq_ctrl.sv
module casc_irq_ctrl
    import casc_irq_pkg::*;
#(
    parameter int N_IRQ     = 8,
    parameter int DATA_W    = 8,
    parameter int VEC_SHIFT = 2,
    localparam int IW       = $clog2(N_IRQ),
    localparam int VEC_W    = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              master_mode,
    input  logic [N_IRQ-1:0]  irq_i,
    output logic              int_o,
    input  logic              ack_i,
    input  logic [IW-1:0]     cas_i,
    output logic [IW-1:0]     cas_o,
    output logic              cas_oe,
    output logic [DATA_W-1:0] data_o,
    output logic              data_oe,
    input  logic              wr_en,
    input  logic [2:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data
);

    logic [N_IRQ-1:0] mask_q, casc_q, isr_q;
    logic [VEC_W-1:0] base_q, vec_addr;
    logic             eoi_stb, raise, isr_any;
    logic [IW-1:0]    win_idx, isr_top;
    ack_state_t       state;
    logic             enter_p1, leave_p1;
    logic [IW-1:0]    win_q;
    logic             win_valid_q, via_slave_q, sel_q;
    logic             isr_set;
    logic [IW-1:0]    isr_set_idx;

    casc_cfg_regs #(.N_IRQ(N_IRQ), .DATA_W(DATA_W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .mask_q(mask_q), .casc_q(casc_q),
        .base_q(base_q), .eoi_stb(eoi_stb)
    );

    casc_prio_resolve #(.N_IRQ(N_IRQ)) u_prio (
        .req(irq_i), .mask(mask_q), .isr(isr_q), .raise(raise),
        .win_idx(win_idx), .isr_any(isr_any), .isr_top(isr_top)
    );

    casc_ack_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .ack_i(ack_i), .state(state),
        .enter_p1(enter_p1), .leave_p1(leave_p1)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) int_o <= 1'b0;
        else        int_o <= raise;
    end

    // Winner capture on the first pulse; slave selection at its end.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            win_q       <= '0;
            win_valid_q <= 1'b0;
            via_slave_q <= 1'b0;
            sel_q       <= 1'b0;
        end else begin
            if (enter_p1) begin
                win_q       <= raise ? win_idx : IW'(N_IRQ - 1);
                win_valid_q <= raise;
                via_slave_q <= master_mode && raise && casc_q[win_idx];
                sel_q       <= 1'b0;
            end else if (leave_p1) begin
                sel_q <= !master_mode && (cas_i == casc_q[IW-1:0]);
            end else if (state == ACK_IDLE) begin
                sel_q       <= 1'b0;
                via_slave_q <= 1'b0;
            end
        end
    end

    always_comb begin
        if (master_mode) begin
            isr_set     = enter_p1 && raise;
            isr_set_idx = win_idx;
        end else begin
            isr_set     = leave_p1 && win_valid_q && (cas_i == casc_q[IW-1:0]);
            isr_set_idx = win_q;
        end
    end

    for (genvar g = 0; g < N_IRQ; g++) begin : g_isr
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                isr_q[g] <= 1'b0;
            else if (isr_set && isr_set_idx == IW'(g))
                isr_q[g] <= 1'b1;
            else if (eoi_stb && isr_any && isr_top == IW'(g))
                isr_q[g] <= 1'b0;
        end
    end

    assign vec_addr = base_q + (VEC_W'(win_q) << VEC_SHIFT);

    always_comb begin
        data_o  = '0;
        data_oe = 1'b0;
        cas_o   = '0;
        cas_oe  = 1'b0;
        unique case (state)
            ACK_P1: begin
                if (master_mode) begin
                    data_oe = 1'b1;
                    data_o  = CALL_OPCODE;
                end
            end
            ACK_P2: begin
                data_oe = master_mode ? !via_slave_q : sel_q;
                data_o  = vec_addr[DATA_W-1:0];
            end
            ACK_P3: begin
                data_oe = master_mode ? !via_slave_q : sel_q;
                data_o  = vec_addr[VEC_W-1:DATA_W];
            end
            ACK_IDLE, ACK_G1, ACK_G2: ;
            default: ;
        endcase
        if (master_mode && via_slave_q && state != ACK_IDLE) begin
            cas_oe = 1'b1;
            cas_o  = win_q;
        end
    end

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (!int_o && !data_oe && !cas_oe));

    // R6
    slave_p1_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!master_mode && state == ACK_P1) |-> !data_oe);

    // R6
    master_p1_call_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (master_mode && state == ACK_P1) |-> (data_oe && data_o == CALL_OPCODE));

    // R11
    slave_cas_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !master_mode |-> !cas_oe);

    // R10
    idle_bus_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ACK_IDLE || state == ACK_G1 || state == ACK_G2) |-> !data_oe);

    // R5
    eoi_one_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_stb && isr_any && !isr_set) |=>
            ($countones(isr_q) == $countones($past(isr_q)) - 1));

    // R4
    int_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(int_o) |-> $past(raise));

endmodule

// File: tb/casc_irq_ctrl_tb.sv
module casc_irq_ctrl_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ack = 1'b0;
    always #2.5 clk = ~clk;

    logic [7:0] m_ext = '0, s1_irq = '0, s2_irq = '0;
    logic       m_int, s1_int, s2_int;
    logic [7:0] m_irq;
    logic [2:0] m_cas, s1_cas, s2_cas, cas_bus;
    logic       m_cas_oe, s1_cas_oe, s2_cas_oe;
    logic [7:0] m_d, s1_d, s2_d;
    logic       m_oe, s1_oe, s2_oe;
    logic [2:0] wa = '0;
    logic [7:0] wd = '0;
    logic [2:0] we = '0;

    assign m_irq   = {m_ext[7], s2_int, m_ext[5:4], s1_int, m_ext[2:0]};
    assign cas_bus = m_cas_oe ? m_cas : 3'b000;

    casc_irq_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .master_mode(1'b1), .irq_i(m_irq), .int_o(m_int),
        .ack_i(ack), .cas_i(3'b000), .cas_o(m_cas), .cas_oe(m_cas_oe),
        .data_o(m_d), .data_oe(m_oe), .wr_en(we[0]), .wr_addr(wa), .wr_data(wd));
    casc_irq_ctrl u_slave (
        .clk(clk), .rst_n(rst_n), .master_mode(1'b0), .irq_i(s1_irq), .int_o(s1_int),
        .ack_i(ack), .cas_i(cas_bus), .cas_o(s1_cas), .cas_oe(s1_cas_oe),
        .data_o(s1_d), .data_oe(s1_oe), .wr_en(we[1]), .wr_addr(wa), .wr_data(wd));
    casc_irq_ctrl u_slave2 (
        .clk(clk), .rst_n(rst_n), .master_mode(1'b0), .irq_i(s2_irq), .int_o(s2_int),
        .ack_i(ack), .cas_i(cas_bus), .cas_o(s2_cas), .cas_oe(s2_cas_oe),
        .data_o(s2_d), .data_oe(s2_oe), .wr_en(we[2]), .wr_addr(wa), .wr_data(wd));

    int checks = 0, fails = 0;
    logic [9:0] expq[$];
    logic prev_oe = 1'b0, cas_bad = 1'b0, done = 1'b0;

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Driver side: queue expected {source, byte}; 0 master, 1 slave, 2 slave2
    task automatic expect_byte(input logic [1:0] src, input logic [7:0] b);
        expq.push_back({src, b});
    endtask

    task automatic wr(input int dev, input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wa = a; wd = d; we = 3'b001 << dev;
        @(negedge clk);
        we = '0;
    endtask

    task automatic settle();
        repeat (3) @(negedge clk);
    endtask

    task automatic ack_seq(input bit chk_cas, input logic [2:0] cas_exp);
        for (int p = 0; p < 3; p++) begin
            @(negedge clk) ack = 1'b1;
            repeat (2) @(negedge clk);
            if (p == 0 && chk_cas) begin
                check("R8 cas_oe", {15'd0, m_cas_oe}, 16'd1);
                check("R8 cas value", {13'd0, m_cas}, {13'd0, cas_exp});
            end
            @(negedge clk) ack = 1'b0;
            repeat (3) @(negedge clk);
        end
    endtask

    // Monitor: pops one expected item per new bus drive
    always @(negedge clk) begin
        if (rst_n) begin
            logic any_oe;
            logic [1:0] src;
            logic [7:0] b;
            logic [9:0] e;
            any_oe = m_oe | s1_oe | s2_oe;
            if (s1_cas_oe || s2_cas_oe) cas_bad = 1'b1;
            if (32'(m_oe) + 32'(s1_oe) + 32'(s2_oe) > 1)
                check("R10 single driver", {13'd0, m_oe, s1_oe, s2_oe}, 16'd0);
            if (any_oe && !prev_oe) begin
                src = m_oe ? 2'd0 : (s1_oe ? 2'd1 : 2'd2);
                b   = m_oe ? m_d : (s1_oe ? s1_d : s2_d);
                if (expq.size() == 0) begin
                    check("R10 unexpected drive", {6'd0, src, b}, 16'h3ff);
                end else begin
                    e = expq.pop_front();
                    check("R6/R7/R9 byte", {6'd0, src, b}, {6'd0, e});
                end
            end
            prev_oe = any_oe;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1
        check("R1 int", {15'd0, m_int}, 16'd0);
        check("R1 data_oe", {13'd0, m_oe, s1_oe, s2_oe}, 16'd0);
        check("R1 cas_oe", {15'd0, m_cas_oe}, 16'd0);
        rst_n = 1'b1;

        wr(0, 3'd0, 8'hC0); wr(0, 3'd1, 8'h48); wr(0, 3'd2, 8'h00); wr(0, 3'd3, 8'h10);
        wr(1, 3'd0, 8'h00); wr(1, 3'd1, 8'h03); wr(1, 3'd2, 8'h00); wr(1, 3'd3, 8'h20);
        wr(2, 3'd0, 8'h00); wr(2, 3'd1, 8'h06); wr(2, 3'd2, 8'h00); wr(2, 3'd3, 8'h30);

        // R2: masked inputs (7 direct, 6 from slave2) leave int low
        m_ext[7] = 1'b1; s2_irq = 8'h02;
        settle();
        check("R2 masked", {15'd0, m_int}, 16'd0);
        m_ext[7] = 1'b0;

        // R2: unmasked direct request
        m_ext[5] = 1'b1;
        settle();
        check("R2 unmasked", {15'd0, m_int}, 16'd1);

        // R7: direct master level 5 -> 0x1014
        expect_byte(2'd0, 8'hCD); expect_byte(2'd0, 8'h14); expect_byte(2'd0, 8'h10);
        ack_seq(1'b0, 3'd0);
        check("R4 same level held", {15'd0, m_int}, 16'd0);

        // R3/R4/R8/R9: slave level 1 beats 2, master input 3 preempts 5
        s1_irq = 8'h06;
        settle();
        check("R4 preempt", {15'd0, m_int}, 16'd1);
        expect_byte(2'd0, 8'hCD); expect_byte(2'd1, 8'h04); expect_byte(2'd1, 8'h20);
        ack_seq(1'b1, 3'd3);
        check("R3 slave int held", {15'd0, s1_int}, 16'd0);
        check("R4 master held", {15'd0, m_int}, 16'd0);

        // R5 on slave: drop level 1, EOI -> level 2 raises
        s1_irq = 8'h04;
        wr(1, 3'd4, 8'h00);
        settle();
        check("R5 slave eoi", {15'd0, s1_int}, 16'd1);
        check("R4 master 3 in service", {15'd0, m_int}, 16'd0);
        wr(0, 3'd4, 8'h00);
        settle();
        check("R5 master eoi frees 3", {15'd0, m_int}, 16'd1);
        expect_byte(2'd0, 8'hCD); expect_byte(2'd1, 8'h08); expect_byte(2'd1, 8'h20);
        ack_seq(1'b1, 3'd3);

        // R5: peel master levels one at a time
        s1_irq = 8'h00;
        wr(1, 3'd4, 8'h00);
        wr(0, 3'd4, 8'h00);
        settle();
        check("R5 level 5 still in service", {15'd0, m_int}, 16'd0);
        wr(0, 3'd4, 8'h00);
        settle();
        check("R5 level 5 freed", {15'd0, m_int}, 16'd1);

        // R10: count restarted, fresh sequence
        expect_byte(2'd0, 8'hCD); expect_byte(2'd0, 8'h14); expect_byte(2'd0, 8'h10);
        ack_seq(1'b0, 3'd0);
        m_ext = '0;

        check("R9 all bytes seen", 16'(expq.size()), 16'd0);
        check("R11 slave cas off", {15'd0, cas_bad}, 16'd0);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule